// File: doc/BRIEF.md
# Retained Memory Boot Validator

After a reset this block checks a small word-addressed memory whose contents may have survived the reset, and repairs it if needed. On a start request it reads a three-word header (two fixed magic words and an error-area length) and judges whether the memory has ever been formatted. If the header is bad, the memory is taken to come from a power-up with no retained content, and a fresh default image is written without raising any alarm. If the header is good, the block runs a CRC-32 over the header, boot-status, override and error areas. It compares the result with the checksum word stored right after the error area and decodes every error-area word. Any mismatch or undecodable word causes the same default image to be written, and a sticky corruption flag is raised.

The memory is reached through one single-port interface. A read returns its data one cycle after the read enable. A run ends with a one-cycle done pulse, together with a held status that tells a valid image, a cold initialisation and a corruption recovery apart. The image layout is: word 0 magic A, word 1 magic B, word 2 error-area length, then `BOOT_WORDS` boot-status words, then `CFG_WORDS` override words, then the error area, then the checksum.

Top module: `pmv_boot_validator`

## Requirements
- R1: While and after reset, `done`, `busy`, the three status bits and `corrupt_flag` are 0, and the block makes no memory access until `start` is seen.
- R2: If word 0 differs from `MAGIC_A` or word 1 differs from `MAGIC_B`, the run ends with `st_cold`=1, rewrites the image, and leaves `corrupt_flag` unchanged.
- R3: An error-area length greater than `MEM_WORDS-ERR_BASE-1` (53 by default, with `ERR_BASE`=10) is implausible and is treated as a cold start. A length equal to that limit is accepted, which puts the checksum at the last word.
- R4: A rebuilt image has `MAGIC_A` at word 0, `MAGIC_B` at word 1, length 0 at word 2, zeros in words 3 to `ERR_BASE-1`, and the checksum of words 0 to `ERR_BASE-1` at word `ERR_BASE`. Exactly `ERR_BASE+1` words are written.
- R5: The checksum is CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF, each word shifted in MSB first, no reflection and no final XOR. It covers words 0 to `ERR_BASE+len-1`, and the checksum sits at word `ERR_BASE+len`.
- R6: A good header, a matching checksum and only decodable entries end the run with `st_valid`=1 and no memory write.
- R7: A good header with a checksum mismatch ends with `st_corrupt`=1, a rebuilt image, and `corrupt_flag`=1.
- R8: An error-area word is decodable when its low byte is 0x51 (flag record), or when it equals 0xC1AA1222 (filler). Any other word causes a corruption recovery even when the checksum matches.
- R9: `corrupt_flag` stays 1 through later runs of any outcome until reset.
- R10: `done` is a single-cycle pulse per run. At that pulse exactly one of `st_valid`, `st_cold`, `st_corrupt` is 1, and it holds until the next start.
- R11: A `start` asserted while `busy` is 1 is ignored: it produces no extra run and no extra `done`.
- R12: The memory read and write enables are never 1 in the same cycle, and the address is always below `MEM_WORDS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a validation run (taken only when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| st_valid | output | 1 | Last run found an intact image |
| st_cold | output | 1 | Last run built a fresh image after a bad header |
| st_corrupt | output | 1 | Last run rebuilt the image after a checksum or entry fault |
| corrupt_flag | output | 1 | Sticky corruption indication, cleared only by reset |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd_en` |

## Verification
The assertions assume that the memory answers every read exactly one cycle later, and that nothing else writes the memory while `busy` is 1, so the words read reflect only this block's own writes. The bench memory model has that fixed one-cycle latency. The bench loads images only between runs, while the block is idle. The only `start` it raises during a run is the deliberate one in the R11 case.

// File: rtl/pmv_pkg.sv
package pmv_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [7:0]  FLAG_TAG = 8'h51;
  localparam logic [31:0] FILL_WORD = 32'hC1AA_1222;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_WRITE
  } pmv_state_e;

  // One 32-bit word folded into the running remainder, MSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [31:0] d);
    logic [31:0] c;
    c = c_in;
    for (int b = 31; b >= 0; b--) begin
      if (c[31] ^ d[b]) c = {c[30:0], 1'b0} ^ CRC_POLY;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/pmv_crc_unit.sv
module pmv_crc_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [31:0] din,
  output logic [31:0] crc
);
  import pmv_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= CRC_INIT;
    else if (en)    crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/pmv_entry_check.sv
module pmv_entry_check (
  input  logic [31:0] word,
  output logic        ok
);
  import pmv_pkg::*;

  always_comb begin
    ok = (word[7:0] == FLAG_TAG) || (word == FILL_WORD);
  end
endmodule

// File: rtl/pmv_boot_validator.sv
module pmv_boot_validator #(
  parameter int          MEM_WORDS  = 64,
  parameter int          BOOT_WORDS = 3,
  parameter int          CFG_WORDS  = 4,
  parameter logic [31:0] MAGIC_A    = 32'hB00C_A11E,
  parameter logic [31:0] MAGIC_B    = 32'h1DEA_F00D,
  localparam int         AW         = $clog2(MEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          st_valid,
  output logic          st_cold,
  output logic          st_corrupt,
  output logic          corrupt_flag,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  import pmv_pkg::*;

  localparam int ERR_BASE = 3 + BOOT_WORDS + CFG_WORDS;
  localparam int MAX_LEN  = MEM_WORDS - ERR_BASE - 1;
  localparam logic [AW:0]   BASE_X = (AW+1)'(ERR_BASE);
  localparam logic [AW-1:0] BASE_A = AW'(ERR_BASE);

  pmv_state_e    state;
  logic [AW-1:0] idx;
  logic [AW-1:0] err_len;
  logic          bad_entry;
  logic          fix_cold;

  logic [31:0] crc_q;
  logic        crc_clr, crc_en;
  logic [31:0] crc_din;
  logic        entry_ok;

  logic [AW:0] idx_x, sum_pos;
  logic        in_crc, is_entry, is_sum, hdr_bad;

  always_comb begin
    idx_x    = {1'b0, idx};
    sum_pos  = BASE_X + {1'b0, err_len};
    in_crc   = idx_x < sum_pos;
    is_sum   = idx_x == sum_pos;
    is_entry = (idx >= BASE_A) && in_crc;
    hdr_bad  = ((idx == AW'(0)) && (mem_rdata != MAGIC_A)) ||
               ((idx == AW'(1)) && (mem_rdata != MAGIC_B)) ||
               ((idx == AW'(2)) && (mem_rdata > 32'(MAX_LEN)));
  end

  // Default image content, address-selected.
  always_comb begin
    if      (idx == AW'(0)) mem_wdata = MAGIC_A;
    else if (idx == AW'(1)) mem_wdata = MAGIC_B;
    else if (idx == BASE_A) mem_wdata = crc_q;
    else                    mem_wdata = 32'h0;
  end

  always_comb begin
    busy      = (state != S_IDLE);
    mem_rd_en = (state == S_RD_REQ);
    mem_wr_en = (state == S_WRITE);
    mem_addr  = idx;
    crc_clr   = ((state == S_IDLE) && start) ||
                ((state == S_RD_WAIT) && (hdr_bad || is_sum));
    crc_en    = ((state == S_RD_WAIT) && in_crc) ||
                ((state == S_WRITE) && (idx < BASE_A));
    crc_din   = (state == S_WRITE) ? mem_wdata : mem_rdata;
  end

  pmv_crc_unit u_crc (
    .clk (clk),
    .rst (rst),
    .clr (crc_clr),
    .en  (crc_en),
    .din (crc_din),
    .crc (crc_q)
  );

  pmv_entry_check u_entry (
    .word (mem_rdata),
    .ok   (entry_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      idx          <= '0;
      err_len      <= '0;
      bad_entry    <= 1'b0;
      fix_cold     <= 1'b0;
      done         <= 1'b0;
      st_valid     <= 1'b0;
      st_cold      <= 1'b0;
      st_corrupt   <= 1'b0;
      corrupt_flag <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            idx        <= '0;
            err_len    <= '0;
            bad_entry  <= 1'b0;
            st_valid   <= 1'b0;
            st_cold    <= 1'b0;
            st_corrupt <= 1'b0;
            state      <= S_RD_REQ;
          end
        end
        S_RD_REQ: state <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (hdr_bad) begin
            fix_cold <= 1'b1;
            idx      <= '0;
            state    <= S_WRITE;
          end else if (is_sum) begin
            if ((mem_rdata != crc_q) || bad_entry) begin
              fix_cold <= 1'b0;
              idx      <= '0;
              state    <= S_WRITE;
            end else begin
              done     <= 1'b1;
              st_valid <= 1'b1;
              state    <= S_IDLE;
            end
          end else begin
            if (idx == AW'(2)) err_len <= mem_rdata[AW-1:0];
            if (is_entry && !entry_ok) bad_entry <= 1'b1;
            idx   <= idx + AW'(1);
            state <= S_RD_REQ;
          end
        end
        S_WRITE: begin
          if (idx == BASE_A) begin
            done       <= 1'b1;
            st_cold    <= fix_cold;
            st_corrupt <= !fix_cold;
            if (!fix_cold) corrupt_flag <= 1'b1;
            state      <= S_IDLE;
          end else begin
            idx <= idx + AW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pmv_checker.sv
module pmv_checker #(
  parameter int MEM_WORDS = 64,
  parameter int AW        = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          st_valid,
  input logic          st_cold,
  input logic          st_corrupt,
  input logic          corrupt_flag,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_addr
);

  // R12
  single_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  // R12
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en || mem_wr_en) |-> (32'(mem_addr) < MEM_WORDS));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd_en && !mem_wr_en));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({st_valid, st_cold, st_corrupt}));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    corrupt_flag |=> corrupt_flag);

  // R2
  cold_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (done && st_cold) |-> (corrupt_flag == $past(corrupt_flag)));

  // R7
  corrupt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (done && st_corrupt) |-> corrupt_flag);

endmodule

bind pmv_boot_validator pmv_checker #(.MEM_WORDS(MEM_WORDS), .AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .done         (done),
  .st_valid     (st_valid),
  .st_cold      (st_cold),
  .st_corrupt   (st_corrupt),
  .corrupt_flag (corrupt_flag),
  .mem_rd_en    (mem_rd_en),
  .mem_wr_en    (mem_wr_en),
  .mem_addr     (mem_addr)
);

// File: tb/tb_pmv_boot_validator.sv
`timescale 1ns/1ps
module tb_pmv_boot_validator;
  localparam int MEM_WORDS = 64;
  localparam int AW        = $clog2(MEM_WORDS);
  localparam int ERR_BASE  = 10;
  localparam int MAX_LEN   = MEM_WORDS - ERR_BASE - 1;
  localparam logic [31:0] MA = 32'hB00C_A11E;
  localparam logic [31:0] MB = 32'h1DEA_F00D;
  localparam logic [31:0] NOPW = 32'hC1AA_1222;
  localparam int K_VALID = 0, K_COLD = 1, K_CORR = 2;

  logic clk = 0, rst = 1, start = 0;
  logic busy, done, st_valid, st_cold, st_corrupt, corrupt_flag;
  logic mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  pmv_boot_validator dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .st_valid(st_valid), .st_cold(st_cold), .st_corrupt(st_corrupt),
    .corrupt_flag(corrupt_flag), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model with one-cycle read latency and a bench load port.
  logic [31:0] tmem [MEM_WORDS];
  logic tb_we = 0;
  logic [AW-1:0] tb_addr = '0;
  logic [31:0] tb_data = '0;
  always @(posedge clk) begin
    if (tb_we)          tmem[tb_addr] <= tb_data;
    else if (mem_wr_en) tmem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= tmem[mem_addr];
  end

  int n_checks = 0, n_fail = 0;
  int wr_cnt = 0, done_cnt = 0, cyc = 0;
  bit running = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the expected bus behaviour.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (mem_wr_en) wr_cnt++;
      if (done) done_cnt++;
      if (mem_rd_en && mem_wr_en) begin
        n_fail++; $display("FAIL R12: rd and wr both 1, actual 1 expected 0");
      end
      if (!running && (mem_rd_en || mem_wr_en || done)) begin
        n_fail++; $display("FAIL R11: activity outside a run, actual 1 expected 0");
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < 32; b++) begin
        bit top = r[31] ^ tmem[w][31-b];
        r = r << 1;
        if (top) r = r ^ 32'h04C1_1DB7;
      end
    return r;
  endfunction

  function automatic int predict();
    int len; bit bad = 0;
    if (tmem[0] != MA || tmem[1] != MB || tmem[2] > MAX_LEN) return K_COLD;
    len = int'(tmem[2]);
    for (int i = 0; i < len; i++)
      if (tmem[ERR_BASE+i][7:0] != 8'h51 && tmem[ERR_BASE+i] != NOPW) bad = 1;
    if (bad || ref_crc(ERR_BASE+len) != tmem[ERR_BASE+len]) return K_CORR;
    return K_VALID;
  endfunction

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_addr = AW'(a); tb_data = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_WORDS; i++) poke(i, 32'h0);
  endtask

  // Writes a formatted image with given entries; fix_sum=0 stores a wrong checksum.
  task automatic build(input logic [31:0] ents[$], input bit fix_sum);
    poke(0, MA); poke(1, MB); poke(2, ents.size());
    for (int i = 3; i < ERR_BASE; i++) poke(i, 32'h0100 * i + 32'h7);
    for (int i = 0; i < ents.size(); i++) poke(ERR_BASE+i, ents[i]);
    @(negedge clk);
    poke(ERR_BASE + ents.size(), fix_sum ? ref_crc(ERR_BASE + ents.size())
                                         : ~ref_crc(ERR_BASE + ents.size()));
  endtask

  task automatic run(input string req, input bit extra_start);
    int exp, kind, t;
    exp = predict();
    wr_cnt = 0; done_cnt = 0; running = 1;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    if (extra_start) begin
      repeat (4) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    check(t < 3000, req, t, 0);
    kind = st_valid ? K_VALID : (st_cold ? K_COLD : K_CORR);
    check($onehot({st_valid, st_cold, st_corrupt}), "R10", {st_valid, st_cold, st_corrupt}, 1);
    check(kind == exp, req, kind, exp);
    repeat (30) @(negedge clk);
    running = 0;
    check(done_cnt == 1, extra_start ? "R11" : "R10", done_cnt, 1);
    check(kind == (st_valid ? K_VALID : (st_cold ? K_COLD : K_CORR)), "R10", kind, exp);
    if (exp == K_VALID) check(wr_cnt == 0, "R6", wr_cnt, 0);
    else begin
      check(wr_cnt == ERR_BASE+1, "R4", wr_cnt, ERR_BASE+1);
      check(tmem[0] == MA && tmem[1] == MB && tmem[2] == 0, "R4", tmem[2], 0);
      for (int i = 3; i < ERR_BASE; i++) check(tmem[i] == 0, "R4", tmem[i], 0);
      check(tmem[ERR_BASE] == ref_crc(ERR_BASE), "R5", tmem[ERR_BASE], ref_crc(ERR_BASE));
    end
  endtask

  initial begin
    logic [31:0] q[$];
    repeat (3) @(negedge clk);
    // R1
    check(!done && !busy && !st_valid && !st_cold && !st_corrupt && !corrupt_flag,
          "R1", {done, busy, st_valid, st_cold, st_corrupt, corrupt_flag}, 0);
    rst = 0;
    clear_mem();
    // R1: no access while idle
    repeat (10) @(negedge clk);
    check(!mem_rd_en && !mem_wr_en && !busy, "R1", {mem_rd_en, mem_wr_en}, 0);

    run("R2", 0);                                   // blank memory: cold
    check(corrupt_flag == 0, "R2", corrupt_flag, 0);
    run("R6", 0);                                   // freshly built image: valid
    q = {32'h0003_0751, NOPW, 32'h0100_2A51};
    build(q, 1);
    run("R8", 0);                                   // decodable entries: valid
    check(st_valid, "R8", st_valid, 1);
    build(q, 0);
    run("R7", 0);                                   // bad checksum
    check(st_corrupt && corrupt_flag, "R7", {st_corrupt, corrupt_flag}, 3);
    run("R9", 0);                                   // later valid run
    check(st_valid && corrupt_flag, "R9", {st_valid, corrupt_flag}, 3);
    poke(1, 32'h0);
    run("R2", 0);                                   // magic B wrong after corruption
    check(st_cold && corrupt_flag, "R9", {st_cold, corrupt_flag}, 3);

    rst = 1; repeat (3) @(negedge clk); rst = 0;
    check(!corrupt_flag, "R1", corrupt_flag, 0);
    build({NOPW, 32'h0000_0052}, 1);                // undecodable entry, good sum
    run("R8", 0);
    check(st_corrupt && corrupt_flag, "R8", {st_corrupt, corrupt_flag}, 3);

    rst = 1; repeat (3) @(negedge clk); rst = 0;
    poke(0, MA); poke(1, MB); poke(2, MAX_LEN + 1);
    run("R3", 0);                                   // implausible length: cold
    check(st_cold && !corrupt_flag, "R3", {st_cold, corrupt_flag}, 2);
    q = {};
    for (int i = 0; i < MAX_LEN; i++) q.push_back((i % 2) ? NOPW : (32'h51 | (i << 8)));
    build(q, 1);
    run("R3", 0);                                   // length at limit: valid
    check(st_valid, "R3", st_valid, 1);
    check(mem_addr < MEM_WORDS, "R12", mem_addr, 0);

    build({32'h0000_1151}, 1);
    run("R11", 1);                                  // second start while busy
    check(st_valid, "R11", st_valid, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule